// File: doc/BRIEF.md
# Cache Victim Replacement Controller

This block chooses which way of a four-way set-associative cache gives up its line when a lookup misses, and it handles the dirty line that leaves. It keeps a true recency order for every set. Each way has a small age counter, where age zero is the most recent way and the top age is the least recent. A hit moves the hit way to the front of its set. A completed fill moves the filled way to the front.

On a miss, the block prefers an empty way. When the set is full, it takes the oldest way. If that victim holds modified data, the block copies its identity into a one-line write-back buffer at the moment the miss is accepted, so that the fill read goes to memory first. After the fill has finished, the buffered line is offered to memory as one 32-byte, four-beat burst write. The offer waits while the memory request queue reports pending work.

The surrounding cache does the tag compare. It presents the set index, the hit result and the per-way valid and modified bits on the access port, and it sees a stall through `acc_ready`. Only one fill is outstanding at a time.

Top module: `cvr_victim_ctrl`

## Requirements
- R1: After reset, `fill_req` and `cast_req` are low and `acc_ready` is high. Every set starts with way 0 as the most recent way and way 3 as the least recent way, with the ages ordered by way index.
- R2: An accepted hit (`acc_hit`=1) makes `acc_hit_way` the most recent way of `acc_set`. Only the ways that were more recent than it move back by one place.
- R3: On an accepted miss where some way has `acc_way_valid` low, the lowest-numbered such way is chosen. From the next cycle, `fill_req` is high and `fill_set`/`fill_way` carry the set and the chosen way.
- R4: On an accepted miss where all four ways are valid, the least recently used way of the set is chosen.
- R5: `fill_req` and its set/way hold until `fill_done` is sampled high. Then `fill_req` drops on the next cycle and the filled way becomes the most recent way of its set. Accepting the miss does not change the recency order.
- R6: When the chosen victim is both valid and modified, its set and way enter the write-back buffer at the edge that accepts the miss. A clean or invalid victim never produces a castout.
- R7: `cast_req` rises only on the edge after one where all of these hold: the buffer is occupied, no fill is outstanding, and `mem_idle` is high. While `mem_idle` is low, the castout waits.
- R8: Once raised, `cast_req` holds `cast_set`/`cast_way` steady until `cast_ack` is sampled high. At that edge the buffer empties, and `cast_req` is low on the next cycle.
- R9: While a fill is outstanding, `acc_ready` is low and presented accesses have no effect on the recency state or on the outputs.
- R10: A miss whose victim is valid and modified, presented while the buffer is occupied, sees `acc_ready` low until the buffer drains. Hits and misses with a clean or invalid victim are still accepted when no fill is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access presented |
| acc_set | input | SET_W | Set index of the access |
| acc_hit | input | 1 | Tag compare result: 1 = hit |
| acc_hit_way | input | WAY_W | Way that hit |
| acc_way_valid | input | WAYS | Valid bit of each way in the set |
| acc_way_dirty | input | WAYS | Modified bit of each way in the set |
| acc_ready | output | 1 | Access accepted this cycle when high |
| fill_req | output | 1 | Fill read outstanding |
| fill_set | output | SET_W | Set being filled |
| fill_way | output | WAY_W | Way being filled |
| fill_done | input | 1 | Fill data has arrived |
| mem_idle | input | 1 | Memory request queue has nothing pending |
| cast_req | output | 1 | Burst write of the buffered line requested |
| cast_set | output | SET_W | Set of the buffered line |
| cast_way | output | WAY_W | Way of the buffered line |
| cast_ack | input | 1 | Castout burst accepted |

## Verification
The bench confines most traffic to a few sets, so that hits, fills and misses keep reshuffling the same recency lists. If the aging rule were wrong, for example aging every way instead of only the more recent ones, a later miss would pick the wrong victim. The bench mixes invalid, clean and modified ways, so a design that evicts a clean line, or that ignores an empty way, shows up as a wrong `fill_way` or as a stray castout. Long stretches with `mem_idle` low, plus dirty misses that arrive while the buffer is full, target two faults: a castout issued ahead of its fill, and a second dirty line overwriting the buffer before it has drained.

// File: rtl/cvr_pkg.sv
// Shared types for the cache victim replacement controller.
// Assumes a single outstanding fill at a time.
package cvr_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } cvr_state_e;
endpackage

// File: rtl/cvr_age_store.sv
// Per-set recency ages: age 0 is the most recent way, WAYS-1 the least recent.
// Assumes WAYS is a power of two and at most one touch per cycle.
module cvr_age_store #(
    parameter int NUM_SETS = 16,
    parameter int WAYS     = 4,
    parameter int SET_W    = $clog2(NUM_SETS),
    parameter int WAY_W    = $clog2(WAYS),
    parameter int AGE_W    = WAY_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SET_W-1:0]             rd_set,
    output logic [WAYS-1:0][AGE_W-1:0]   rd_age,
    input  logic                         touch_en,
    input  logic [SET_W-1:0]             touch_set,
    input  logic [WAY_W-1:0]             touch_way
);
    logic [WAYS-1:0][AGE_W-1:0] age_q [NUM_SETS];
    logic [AGE_W-1:0]           touched_age;

    // Read port: ages of the set under lookup.
    assign rd_age      = age_q[rd_set];
    assign touched_age = age_q[touch_set][touch_way];

    // Age update: the touched way goes to zero, and the more recent ways age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= AGE_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[touch_set][w] <= '0;
                end else if (age_q[touch_set][w] < touched_age) begin
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cvr_victim_pick.sv
// Combinational victim choice: the lowest-numbered invalid way, otherwise the oldest way.
// Assumes the ages of a set form a permutation of 0..WAYS-1.
module cvr_victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS),
    parameter int AGE_W = WAY_W
) (
    input  logic [WAYS-1:0][AGE_W-1:0] age,
    input  logic [WAYS-1:0]            way_valid,
    output logic [WAY_W-1:0]           victim_way
);
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

    // Scan for an empty way first, then fall back to the oldest way.
    always_comb begin
        logic found;
        found      = 1'b0;
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!way_valid[w] && !found) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age[w] == OLDEST) begin
                    victim_way = WAY_W'(w);
                end
            end
        end
    end
endmodule

// File: rtl/cvr_wb_buffer.sv
// One-line write-back buffer that holds the set/way of a modified victim and
// requests its burst castout. Assumes load_en is never raised while occupied.
module cvr_wb_buffer #(
    parameter int SET_W = 4,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [SET_W-1:0] load_set,
    input  logic [WAY_W-1:0] load_way,
    input  logic             no_fill,
    input  logic             mem_idle,
    input  logic             cast_ack,
    output logic             occupied,
    output logic             cast_req,
    output logic [SET_W-1:0] cast_set,
    output logic [WAY_W-1:0] cast_way
);
    // Buffer and request state: load, drain when memory is idle, clear on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occupied <= 1'b0;
            cast_req <= 1'b0;
            cast_set <= '0;
            cast_way <= '0;
        end else if (load_en) begin
            occupied <= 1'b1;
            cast_set <= load_set;
            cast_way <= load_way;
        end else if (cast_req && cast_ack) begin
            occupied <= 1'b0;
            cast_req <= 1'b0;
        end else if (occupied && !cast_req && no_fill && mem_idle) begin
            cast_req <= 1'b1;
        end
    end
endmodule

// File: rtl/cvr_victim_ctrl.sv
// Top level: recency tracking, victim choice, fill sequencing and castout staging
// for a four-way cache. Assumes one fill at a time and tag compare done upstream.
module cvr_victim_ctrl #(
    parameter int NUM_SETS = 16,
    parameter int WAYS     = 4,
    parameter int SET_W    = $clog2(NUM_SETS),
    parameter int WAY_W    = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic             acc_hit,
    input  logic [WAY_W-1:0] acc_hit_way,
    input  logic [WAYS-1:0]  acc_way_valid,
    input  logic [WAYS-1:0]  acc_way_dirty,
    output logic             acc_ready,
    output logic             fill_req,
    output logic [SET_W-1:0] fill_set,
    output logic [WAY_W-1:0] fill_way,
    input  logic             fill_done,
    input  logic             mem_idle,
    output logic             cast_req,
    output logic [SET_W-1:0] cast_set,
    output logic [WAY_W-1:0] cast_way,
    input  logic             cast_ack
);
    import cvr_pkg::*;

    localparam int AGE_W = WAY_W;

    cvr_state_e                 state_q;
    logic [WAYS-1:0][AGE_W-1:0] set_age;
    logic [WAY_W-1:0]           victim;
    logic                       victim_dirty;
    logic                       wb_busy;
    logic                       acc_fire;
    logic                       miss_fire;
    logic                       fill_fin;
    logic                       touch_en;
    logic [SET_W-1:0]           touch_set;
    logic [WAY_W-1:0]           touch_way;

    cvr_age_store #(
        .NUM_SETS(NUM_SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W), .AGE_W(AGE_W)
    ) u_ages (
        .clk(clk), .rst_n(rst_n), .rd_set(acc_set), .rd_age(set_age),
        .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way)
    );

    cvr_victim_pick #(
        .WAYS(WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W)
    ) u_pick (
        .age(set_age), .way_valid(acc_way_valid), .victim_way(victim)
    );

    cvr_wb_buffer #(
        .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_wb (
        .clk(clk), .rst_n(rst_n),
        .load_en(miss_fire && victim_dirty), .load_set(acc_set), .load_way(victim),
        .no_fill(state_q == ST_IDLE), .mem_idle(mem_idle), .cast_ack(cast_ack),
        .occupied(wb_busy), .cast_req(cast_req), .cast_set(cast_set), .cast_way(cast_way)
    );

    // Accept decode: stall during a fill, or for a dirty eviction while the buffer is full.
    always_comb begin
        victim_dirty = acc_way_valid[victim] && acc_way_dirty[victim];
        acc_ready    = (state_q == ST_IDLE) && !(acc_valid && !acc_hit && victim_dirty && wb_busy);
        acc_fire     = acc_valid && acc_ready;
        miss_fire    = acc_fire && !acc_hit;
        fill_fin     = (state_q == ST_FILL) && fill_done;
    end

    // Recency touch source: a completed fill, or an accepted hit.
    always_comb begin
        touch_en  = fill_fin || (acc_fire && acc_hit);
        touch_set = fill_fin ? fill_set : acc_set;
        touch_way = fill_fin ? fill_way : acc_hit_way;
    end

    // Fill sequencer: capture the miss target, wait for the fill data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            fill_set <= '0;
            fill_way <= '0;
        end else if (state_q == ST_IDLE) begin
            if (miss_fire) begin
                state_q  <= ST_FILL;
                fill_set <= acc_set;
                fill_way <= victim;
            end
        end else if (fill_done) begin
            state_q <= ST_IDLE;
        end
    end

    assign fill_req = (state_q == ST_FILL);
endmodule

// File: rtl/cvr_victim_ctrl_chk.sv
// Protocol checker for the victim replacement controller, bound to the top level.
// Assumes the same parameters as the bound instance.
module cvr_victim_ctrl_chk #(
    parameter int SET_W = 4,
    parameter int WAY_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_ready,
    input logic             fill_req,
    input logic [SET_W-1:0] fill_set,
    input logic [WAY_W-1:0] fill_way,
    input logic             fill_done,
    input logic             mem_idle,
    input logic             cast_req,
    input logic [SET_W-1:0] cast_set,
    input logic [WAY_W-1:0] cast_way,
    input logic             cast_ack
);
    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req && !fill_done |=> fill_req && $stable(fill_set) && $stable(fill_way)); // R5
    AST_FILL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req && fill_done |=> !fill_req); // R5
    AST_NO_ACCEPT_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !acc_ready); // R9
    AST_CAST_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cast_req) |-> $past(!fill_req) && $past(mem_idle)); // R7
    AST_CAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cast_req && !cast_ack |=> cast_req && $stable(cast_set) && $stable(cast_way)); // R8
    AST_CAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cast_req && cast_ack |=> !cast_req); // R8
endmodule

bind cvr_victim_ctrl cvr_victim_ctrl_chk #(.SET_W(SET_W), .WAY_W(WAY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_ready(acc_ready),
    .fill_req(fill_req), .fill_set(fill_set), .fill_way(fill_way), .fill_done(fill_done),
    .mem_idle(mem_idle), .cast_req(cast_req), .cast_set(cast_set), .cast_way(cast_way),
    .cast_ack(cast_ack)
);

// File: tb/cvr_victim_ctrl_test.sv
`timescale 1ns/1ps
module cvr_victim_ctrl_test;
    localparam int NSETS = 16;
    localparam int NWAYS = 4;
    localparam int SW    = 4;
    localparam int WW    = 2;
    localparam int NCYC  = 6000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [SW-1:0] acc_set = '0;
    logic          acc_hit = 1'b0;
    logic [WW-1:0] acc_hit_way = '0;
    logic [3:0]    acc_way_valid = '0;
    logic [3:0]    acc_way_dirty = '0;
    logic          acc_ready;
    logic          fill_req;
    logic [SW-1:0] fill_set;
    logic [WW-1:0] fill_way;
    logic          fill_done = 1'b0;
    logic          mem_idle = 1'b0;
    logic          cast_req;
    logic [SW-1:0] cast_set;
    logic [WW-1:0] cast_way;
    logic          cast_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cvr_victim_ctrl uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_hit_way(acc_hit_way), .acc_way_valid(acc_way_valid),
        .acc_way_dirty(acc_way_dirty), .acc_ready(acc_ready), .fill_req(fill_req),
        .fill_set(fill_set), .fill_way(fill_way), .fill_done(fill_done),
        .mem_idle(mem_idle), .cast_req(cast_req), .cast_set(cast_set),
        .cast_way(cast_way), .cast_ack(cast_ack)
    );

    // Reference model: recency lists (index 0 = most recent) and transaction flags.
    int order [NSETS][NWAYS];
    bit m_busy, m_wb, m_cast;
    int m_fset, m_fway, m_wset, m_wway;

    function automatic void model_reset();
        for (int s = 0; s < NSETS; s++)
            for (int p = 0; p < NWAYS; p++) order[s][p] = p;
        m_busy = 0; m_wb = 0; m_cast = 0;
        m_fset = 0; m_fway = 0; m_wset = 0; m_wway = 0;
    endfunction

    function automatic void touch(int s, int w);
        int pos = 0;
        for (int p = 0; p < NWAYS; p++) if (order[s][p] == w) pos = p;
        for (int p = pos; p > 0; p--) order[s][p] = order[s][p-1];
        order[s][0] = w;
    endfunction

    function automatic int pick_victim();
        for (int w = 0; w < NWAYS; w++) if (!acc_way_valid[w]) return w;
        return order[acc_set][NWAYS-1];
    endfunction

    function automatic bit exp_ready();
        int v;
        if (m_busy) return 0;
        if (!acc_valid || acc_hit) return 1;
        v = pick_victim();
        return !(acc_way_valid[v] && acc_way_dirty[v] && m_wb);
    endfunction

    // Model step on each rising edge, from the inputs sampled there.
    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit fire, old_busy;
            int v;
            fire = acc_valid && exp_ready();
            old_busy = m_busy;
            if (m_busy && fill_done) begin
                touch(m_fset, m_fway);
                m_busy = 0;
            end
            if (m_cast && cast_ack) begin
                m_wb = 0; m_cast = 0;
            end else if (m_wb && !m_cast && !old_busy && mem_idle) begin
                m_cast = 1;
            end
            if (fire) begin
                if (acc_hit) begin
                    touch(acc_set, acc_hit_way);
                end else begin
                    v = pick_victim();
                    if (acc_way_valid[v] && acc_way_dirty[v]) begin
                        m_wb = 1; m_wset = acc_set; m_wway = v;
                    end
                    m_busy = 1; m_fset = acc_set; m_fway = v;
                end
            end
        end
    end

    task automatic cmp(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_regs();
        cmp("R5 R9", "fill_req", fill_req, m_busy);
        if (m_busy) begin
            cmp("R3", "fill_set", fill_set, m_fset);
            cmp("R2 R3 R4", "fill_way", fill_way, m_fway);
        end
        cmp("R6 R7 R8", "cast_req", cast_req, m_cast);
        if (m_cast) begin
            cmp("R6", "cast_set", cast_set, m_wset);
            cmp("R6", "cast_way", cast_way, m_wway);
        end
    endtask

    task automatic drive(int cyc);
        int narrow = (cyc / 700) % 2;
        acc_valid     = ($urandom % 10) < 7;
        acc_set       = narrow ? SW'($urandom % 2) : SW'($urandom % NSETS);
        acc_hit       = ($urandom % 10) < 4;
        acc_hit_way   = WW'($urandom % NWAYS);
        acc_way_valid = 4'($urandom) | 4'($urandom) | 4'($urandom);
        if (acc_hit) acc_way_valid[acc_hit_way] = 1'b1;
        acc_way_dirty = 4'($urandom);
        fill_done     = ($urandom % 10) < 3;
        mem_idle      = ((cyc / 40) % 3 == 0) ? 1'b0 : (($urandom % 10) < 6);
        cast_ack      = ($urandom % 2) == 1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cmp("R1", "fill_req", fill_req, 0);
        cmp("R1", "cast_req", cast_req, 0);
        cmp("R1", "acc_ready", acc_ready, 1);
        // R1 R4: all-valid miss on a fresh set picks way 3
        acc_valid = 1; acc_set = 5; acc_hit = 0; acc_way_valid = 4'hF; acc_way_dirty = 4'h8;
        mem_idle = 0; fill_done = 0; cast_ack = 0;
        @(negedge clk);
        cmp("R1 R4", "fill_way", fill_way, 3);
        cmp("R6", "cast_req", cast_req, 0);
        acc_valid = 0;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            @(negedge clk);
            check_regs();
            drive(cyc);
            #1;
            cmp("R9 R10", "acc_ready", acc_ready, exp_ready());
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #((NCYC + 500) * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule